// File: doc/BRIEF.md
# Circular Buffer Access Splitter

This block turns one circular-addressed load or store into the physical memory accesses that carry it out. Each request gives a buffer base address, a buffer length in bytes, the current byte index into the buffer, the access size and a load/store flag. If the requested bytes fit below the end of the buffer, the block issues one access at base plus index. If they run past the end, it issues two accesses on consecutive cycles. The first access covers the bytes up to the end of the buffer. The second access starts again at the base and covers the rest.

Each access carries its own byte count. The block holds the count for the second part in dedicated registers, so the first part is always sized from its own calculation. A request that arrives just after another split request still gets correct sizes for both of its parts. While the second part is being issued, the block raises a stall for one cycle. The issuing stage must hold its request during that cycle. When the last access of a request goes out, the block also reports the updated index, which is (index + bytes) modulo length.

Top module: `circ_split`

## Requirements
- R1: While rst_ni is low, acc_valid_o, stall_o and idx_upd_o are 0.
- R2: A request is accepted on a rising edge where req_valid_i is 1 and stall_o is 0. The size code sets the byte count: 0 gives 1 byte, 1 gives 2, 2 gives 4 and 3 gives 8. If index + bytes < length, one cycle after acceptance there is a single access with acc_addr_o = base + index, acc_bytes_o = bytes, acc_part_o = 0 and acc_last_o = 1.
- R3: If index + bytes > length, the request is split. One cycle after acceptance the block issues a first access with address base + index, length − index bytes, part 0 and last 0. In the next cycle it issues a second access with address base, bytes − (length − index) bytes, part 1 and last 1.
- R4: When a split request is accepted directly after the second part of an earlier split, both of its parts still carry their own byte counts as given in R3.
- R5: If index + bytes = length, the request is issued as a single access and the new index is 0.
- R6: stall_o is 1 in exactly the cycle in which the second part of a split is pending, and never for two cycles in a row. A request presented while stall_o is 1 is ignored and causes no access.
- R7: idx_upd_o is 1 together with the last access of each request, and idx_o then equals (index + bytes) modulo length. idx_upd_o is 0 in every other cycle.
- R8: A half-word access (size code 1) with an even index and an even length is never split.
- R9: acc_store_o equals the req_store_i of the request on every access of that request, including both parts of a split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_base_i | input | ADDR_W | Buffer base address |
| req_len_i | input | IDX_W | Buffer length in bytes |
| req_idx_i | input | IDX_W | Current byte index |
| req_size_i | input | 2 | Size code (0:1, 1:2, 2:4, 3:8 bytes) |
| req_store_i | input | 1 | 1 for store, 0 for load |
| stall_o | output | 1 | Second part pending; hold the request |
| acc_valid_o | output | 1 | Access issued this cycle |
| acc_addr_o | output | ADDR_W | Access byte address |
| acc_bytes_o | output | 4 | Access byte count |
| acc_part_o | output | 1 | 0 for first part, 1 for second part |
| acc_last_o | output | 1 | Last access of the request |
| acc_store_o | output | 1 | Store flag of the access |
| idx_upd_o | output | 1 | idx_o carries a new index |
| idx_o | output | IDX_W | Updated index |

## Verification
The assertions assume that every request has an index below the length and a length of at least 8 bytes, so a single access can wrap at most once. They also assume that half-word requests use an even index on an even length. The stimulus builds every length as a multiple of 8 between 8 and 64 bytes and draws the index below that length. It clears the low index bit for half-word requests and holds each request unchanged until it is accepted. Directed cases cover an exact fit at the end of the buffer, two split requests issued back to back, and a request that is presented only while stall_o is high and then withdrawn.

// File: rtl/circ_split_pkg.sv
package circ_split_pkg;
  localparam int unsigned BYTES_W = 4;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SECOND = 1'b1
  } split_state_e;

  function automatic logic [BYTES_W-1:0] size_bytes(acc_size_e s);
    return BYTES_W'(1) << s;
  endfunction
endpackage

// File: rtl/circ_split_calc.sv
module circ_split_calc
  import circ_split_pkg::*;
#(
  parameter int unsigned IDX_W = 16
) (
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [IDX_W-1:0]   len_i,
  input  acc_size_e          size_i,
  output logic               wrap_o,
  output logic [BYTES_W-1:0] first_bytes_o,
  output logic [BYTES_W-1:0] second_bytes_o,
  output logic [IDX_W-1:0]   idx_new_o
);
  localparam int unsigned SUM_W = IDX_W + 1;

  logic [BYTES_W-1:0] nbytes;
  logic [SUM_W-1:0]   sum;
  logic [SUM_W-1:0]   len_ext;
  logic [SUM_W-1:0]   folded;
  logic [IDX_W-1:0]   room;
  logic               reach;

  always_comb begin
    nbytes         = size_bytes(size_i);
    sum            = {1'b0, idx_i} + SUM_W'(nbytes);
    len_ext        = {1'b0, len_i};
    wrap_o         = sum > len_ext;
    reach          = sum >= len_ext;
    folded         = sum - len_ext;
    idx_new_o      = reach ? folded[IDX_W-1:0] : sum[IDX_W-1:0];
    room           = len_i - idx_i;
    // room < nbytes whenever wrap_o, so the low bits carry it fully
    first_bytes_o  = wrap_o ? room[BYTES_W-1:0] : nbytes;
    second_bytes_o = wrap_o ? (nbytes - room[BYTES_W-1:0]) : '0;
  end
endmodule

// File: rtl/circ_split_addr.sv
module circ_split_addr #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] first_addr_o,
  output logic [ADDR_W-1:0] second_addr_o
);
  always_comb begin
    first_addr_o  = base_i + ADDR_W'(idx_i);
    second_addr_o = base_i;
  end
endmodule

// File: rtl/circ_split_seq.sv
module circ_split_seq
  import circ_split_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               accept_i,
  input  logic               wrap_i,
  input  logic [BYTES_W-1:0] first_bytes_i,
  input  logic [BYTES_W-1:0] second_bytes_i,
  input  logic [ADDR_W-1:0]  first_addr_i,
  input  logic [ADDR_W-1:0]  second_addr_i,
  input  logic               store_i,
  input  logic [IDX_W-1:0]   idx_new_i,
  output logic               stall_o,
  output logic               acc_valid_o,
  output logic [ADDR_W-1:0]  acc_addr_o,
  output logic [BYTES_W-1:0] acc_bytes_o,
  output logic               acc_part_o,
  output logic               acc_last_o,
  output logic               acc_store_o,
  output logic               idx_upd_o,
  output logic [IDX_W-1:0]   idx_o
);
  split_state_e       state_q;
  // second part kept apart so part one never reads its size
  logic [ADDR_W-1:0]  sec_addr_q;
  logic [BYTES_W-1:0] sec_bytes_q;
  logic               sec_store_q;
  logic [IDX_W-1:0]   sec_idx_q;
  logic [BYTES_W:0]   tot_q;

  assign stall_o = (state_q == ST_SECOND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      acc_valid_o <= 1'b0;
      acc_addr_o  <= '0;
      acc_bytes_o <= '0;
      acc_part_o  <= 1'b0;
      acc_last_o  <= 1'b0;
      acc_store_o <= 1'b0;
      idx_upd_o   <= 1'b0;
      idx_o       <= '0;
      sec_addr_q  <= '0;
      sec_bytes_q <= '0;
      sec_store_q <= 1'b0;
      sec_idx_q   <= '0;
      tot_q       <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          acc_valid_o <= accept_i;
          idx_upd_o   <= accept_i && !wrap_i;
          if (accept_i) begin
            acc_addr_o  <= first_addr_i;
            acc_bytes_o <= first_bytes_i;
            acc_part_o  <= 1'b0;
            acc_last_o  <= !wrap_i;
            acc_store_o <= store_i;
            if (!wrap_i) idx_o <= idx_new_i;
            sec_addr_q  <= second_addr_i;
            sec_bytes_q <= second_bytes_i;
            sec_store_q <= store_i;
            sec_idx_q   <= idx_new_i;
            tot_q       <= {1'b0, first_bytes_i} + {1'b0, second_bytes_i};
            state_q     <= wrap_i ? ST_SECOND : ST_IDLE;
          end
        end
        ST_SECOND: begin
          acc_valid_o <= 1'b1;
          acc_addr_o  <= sec_addr_q;
          acc_bytes_o <= sec_bytes_q;
          acc_part_o  <= 1'b1;
          acc_last_o  <= 1'b1;
          acc_store_o <= sec_store_q;
          idx_upd_o   <= 1'b1;
          idx_o       <= sec_idx_q;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_split_pair_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_o && !acc_last_o |=> acc_valid_o && acc_part_o && acc_last_o);

  assert_part_order_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_o && acc_part_o |-> $past(acc_valid_o) && !$past(acc_part_o));

  assert_parts_sum_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_o && acc_part_o |->
      ({1'b0, acc_bytes_o} + {1'b0, $past(acc_bytes_o)}) == tot_q);

  assert_stall_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);
endmodule

// File: rtl/circ_split.sv
module circ_split
  import circ_split_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_base_i,
  input  logic [IDX_W-1:0]   req_len_i,
  input  logic [IDX_W-1:0]   req_idx_i,
  input  logic [1:0]         req_size_i,
  input  logic               req_store_i,
  output logic               stall_o,
  output logic               acc_valid_o,
  output logic [ADDR_W-1:0]  acc_addr_o,
  output logic [BYTES_W-1:0] acc_bytes_o,
  output logic               acc_part_o,
  output logic               acc_last_o,
  output logic               acc_store_o,
  output logic               idx_upd_o,
  output logic [IDX_W-1:0]   idx_o
);
  acc_size_e          size;
  logic               accept;
  logic               wrap;
  logic [BYTES_W-1:0] first_bytes;
  logic [BYTES_W-1:0] second_bytes;
  logic [IDX_W-1:0]   idx_new;
  logic [ADDR_W-1:0]  first_addr;
  logic [ADDR_W-1:0]  second_addr;

  assign size   = acc_size_e'(req_size_i);
  assign accept = req_valid_i && !stall_o;

  circ_split_calc #(.IDX_W(IDX_W)) u_calc (
    .idx_i          (req_idx_i),
    .len_i          (req_len_i),
    .size_i         (size),
    .wrap_o         (wrap),
    .first_bytes_o  (first_bytes),
    .second_bytes_o (second_bytes),
    .idx_new_o      (idx_new)
  );

  circ_split_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .base_i        (req_base_i),
    .idx_i         (req_idx_i),
    .first_addr_o  (first_addr),
    .second_addr_o (second_addr)
  );

  circ_split_seq #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .accept_i       (accept),
    .wrap_i         (wrap),
    .first_bytes_i  (first_bytes),
    .second_bytes_i (second_bytes),
    .first_addr_i   (first_addr),
    .second_addr_i  (second_addr),
    .store_i        (req_store_i),
    .idx_new_i      (idx_new),
    .stall_o        (stall_o),
    .acc_valid_o    (acc_valid_o),
    .acc_addr_o     (acc_addr_o),
    .acc_bytes_o    (acc_bytes_o),
    .acc_part_o     (acc_part_o),
    .acc_last_o     (acc_last_o),
    .acc_store_o    (acc_store_o),
    .idx_upd_o      (idx_upd_o),
    .idx_o          (idx_o)
  );

  logic exact_fit;
  assign exact_fit = (({1'b0, req_idx_i} + (IDX_W+1)'(size_bytes(size))) == {1'b0, req_len_i});

  assert_bytes_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_o |-> (acc_bytes_o != '0) && (acc_bytes_o <= BYTES_W'(8)));

  assert_exact_fit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && exact_fit |=> acc_last_o && idx_upd_o && (idx_o == '0));

  assert_half_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && (size == SZ_HALF) && !req_idx_i[0] && !req_len_i[0] |=> acc_last_o);

  assert_store_pair_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_o && acc_part_o |-> acc_store_o == $past(acc_store_o));
endmodule

// File: tb/circ_split_tb_top.sv
module circ_split_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 50000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_base_i = '0;
  logic [15:0] req_len_i = 16'd8;
  logic [15:0] req_idx_i = '0;
  logic [1:0]  req_size_i = '0;
  logic        req_store_i = 1'b0;
  logic        stall_o, acc_valid_o, acc_part_o, acc_last_o, acc_store_o, idx_upd_o;
  logic [31:0] acc_addr_o;
  logic [3:0]  acc_bytes_o;
  logic [15:0] idx_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  circ_split dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_base_i, .req_len_i, .req_idx_i,
    .req_size_i, .req_store_i, .stall_o, .acc_valid_o, .acc_addr_o,
    .acc_bytes_o, .acc_part_o, .acc_last_o, .acc_store_o, .idx_upd_o, .idx_o
  );

  typedef struct {
    bit          v;
    logic [31:0] addr;
    int          bytes;
    bit          part;
    bit          last;
    bit          store;
    bit          upd;
    int          idx;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  bit   prev_part1 = 0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model: one expected output set per clock
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q.delete();
      cur = '{v:0, addr:0, bytes:0, part:0, last:0, store:0, upd:0, idx:0, tag:"R1"};
      prev_part1 = 0;
    end else begin
      if (q.size() > 0) begin
        cur = q.pop_front();
      end else if (req_valid_i) begin
        int n, s, l, i, ni;
        string t;
        n = 1 << req_size_i;
        i = int'(req_idx_i);
        l = int'(req_len_i);
        s = i + n;
        ni = (s >= l) ? s - l : s;
        t = (req_size_i == 2'd1) ? "R8" : ((s == l) ? "R5" : "R2");
        if (s > l) begin
          t = prev_part1 ? "R4" : "R3";
          cur = '{v:1, addr:req_base_i + 32'(i), bytes:l - i, part:0, last:0,
                  store:req_store_i, upd:0, idx:0, tag:t};
          q.push_back('{v:1, addr:req_base_i, bytes:n - (l - i), part:1, last:1,
                        store:req_store_i, upd:1, idx:ni, tag:t});
        end else begin
          cur = '{v:1, addr:req_base_i + 32'(i), bytes:n, part:0, last:1,
                  store:req_store_i, upd:1, idx:ni, tag:t};
        end
      end else begin
        cur = '{v:0, addr:0, bytes:0, part:0, last:0, store:0, upd:0, idx:0, tag:"R6"};
      end
      prev_part1 = cur.v && cur.part;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      check(acc_valid_o == cur.v, cur.tag, "valid", acc_valid_o, cur.v);
      if (cur.v) begin
        check(acc_addr_o == cur.addr, cur.tag, "addr", acc_addr_o, cur.addr);
        check(int'(acc_bytes_o) == cur.bytes, cur.tag, "bytes", acc_bytes_o, cur.bytes);
        check(acc_part_o == cur.part, cur.tag, "part", acc_part_o, cur.part);
        check(acc_last_o == cur.last, cur.tag, "last", acc_last_o, cur.last);
        check(acc_store_o == cur.store, "R9", "store", acc_store_o, cur.store);
      end
      check(idx_upd_o == cur.upd, "R7", "idx_upd", idx_upd_o, cur.upd);
      if (cur.upd) check(int'(idx_o) == cur.idx, "R7", "idx", idx_o, cur.idx);
      check(stall_o == (q.size() > 0), "R6", "stall", stall_o, q.size() > 0);
    end
  end

  task automatic send(logic [31:0] b, int l, int i, int sz, bit st);
    req_valid_i = 1'b1;
    req_base_i  = b;
    req_len_i   = 16'(l);
    req_idx_i   = 16'(i);
    req_size_i  = 2'(sz);
    req_store_i = st;
    while (stall_o) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic idle(int c);
    req_valid_i = 1'b0;
    repeat (c) @(negedge clk_i);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(acc_valid_o == 0, "R1", "valid in reset", acc_valid_o, 0);
    check(stall_o == 0, "R1", "stall in reset", stall_o, 0);
    check(idx_upd_o == 0, "R1", "idx_upd in reset", idx_upd_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    send(32'h1000, 16, 4, 2, 0);    // R2 plain word
    send(32'h1000, 16, 12, 2, 0);   // R5 exact fit
    send(32'h1000, 16, 14, 2, 0);   // R3 split 2+2
    send(32'h1000, 16, 10, 3, 0);   // R3 split 6+2
    send(32'h1000, 16, 13, 3, 0);   // R4 split 3+5 right after split
    send(32'h1000, 16, 15, 0, 0);   // R5 byte at end
    send(32'h1000, 16, 14, 1, 0);   // R8 half at end
    send(32'h2000, 24, 21, 2, 1);   // R9 store split
    idle(2);

    // R6: request shown only during stall must be dropped
    req_valid_i = 1'b1; req_base_i = 32'h3000; req_len_i = 16'd8;
    req_idx_i = 16'd6; req_size_i = 2'd3; req_store_i = 1'b0;
    @(negedge clk_i);
    req_idx_i = 16'd0; req_size_i = 2'd0; req_store_i = 1'b1;
    @(negedge clk_i);
    idle(3);

    for (int k = 0; k < 400; k++) begin
      int l, i, sz;
      l  = 8 * $urandom_range(1, 8);
      i  = $urandom_range(0, l - 1);
      sz = $urandom_range(0, 3);
      if (sz == 1) i = i & ~1;
      send($urandom, l, i, sz, 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule